// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from one asynchronous serial line that idles high. It waits for the line to fall from 1 to 0. That edge fixes the bit grid for the rest of the character. Each later bit is taken at the centre of its cell, and the cell length is counted in pulses of an oversampling clock enable. The bit rate can be one, sixteen, thirty-two or sixty-four enable pulses per bit.

A character is 5 to 8 data bits, sent least significant bit first. An optional parity bit follows, and then a single stop bit. The receiver writes each finished character, with its parity-error and framing-error flags, into a one-entry holding register. A consumer reads that register through a valid/ready handshake. A strip option can drop every character equal to a programmed match value before it reaches the holding register. Configuration is expected to stay constant while a character is being received.

The framing state machine has five states:
- `ST_IDLE` waits for a low sample.
- `ST_START` re-checks the start bit at its half-bit point. This state is used in the oversampled modes only.
- `ST_DATA` collects the data bits.
- `ST_PARITY` takes the parity bit.
- `ST_STOP` takes the stop bit.

The transitions are:
- `ST_IDLE`→`ST_START` on a low sample in an oversampled mode.
- `ST_IDLE`→`ST_DATA` on a low sample in x1 mode.
- `ST_START`→`ST_IDLE` when the half-bit sample is high (a glitch).
- `ST_START`→`ST_DATA` when the half-bit sample is low.
- `ST_DATA`→`ST_PARITY` or `ST_DATA`→`ST_STOP` after the last data bit, depending on whether parity is enabled.
- `ST_PARITY`→`ST_STOP` after the parity bit.
- `ST_STOP`→`ST_IDLE` after the stop sample.

Top module: `serial_char_rx`

## Requirements
- R1: After reset, `out_valid`, `out_overrun`, `out_par_err` and `out_frm_err` are 0.
- R2: In the oversampled modes, data bits are sampled at the centre of each cell. The line value during the first three and last three enable pulses of a data cell has no effect on the received data.
- R3: In the oversampled modes, a low level that has returned high by the start bit's half-bit point is discarded. No character results, and a following normal character is received correctly.
- R4: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The first bit received lands in `out_data[0]`, and unused upper bits of `out_data` read as 0.
- R5: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_even` = 1 means the data bits plus the parity bit must hold an even number of ones, and 0 means an odd number. A mismatch sets `out_par_err` with that character. When `cfg_par_en` is 0, no parity bit is expected and `out_par_err` is 0.
- R6: Exactly one stop bit is checked. A stop bit sampled as 0 sets `out_frm_err` with that character. Extra high stop time before the next start is accepted.
- R7: When `cfg_strip_en` is 1, a character whose right-justified 8-bit value equals `cfg_match` is dropped and never appears on the output. Its error flags do not matter. Other characters are delivered normally.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and the flags stay unchanged. A cycle with both `out_valid` and `out_ready` high empties the holding register.
- R9: If a character completes while the holding register is full and is not being read, the held character is kept and `out_overrun` becomes 1. The flag clears when that character is read.
- R10: `cfg_mode` selects the enable pulses per bit: 0 gives 1 (x1), 1 gives 16, 2 gives 32 and 3 gives 64. In x1 mode, the enable pulse that sees the line low is the start bit, and each following enable pulse samples one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Oversampling clock enable, one pulse per sample slot |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_mode | input | 2 | Enable pulses per bit: 0=1, 1=16, 2=32, 3=64 |
| cfg_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_strip_en | input | 1 | Drop characters equal to `cfg_match` |
| cfg_match | input | 8 | Value compared against the right-justified character |
| out_ready | input | 1 | Consumer accepts the held character |
| out_valid | output | 1 | Holding register contains a character |
| out_data | output | 8 | Received character, right-justified |
| out_par_err | output | 1 | Parity error flag of the held character |
| out_frm_err | output | 1 | Framing error flag of the held character |
| out_overrun | output | 1 | A later character was lost while this one was held |

## Verification
The hardest situations to reach from the ports are those that depend on where the receiver samples inside a cell. One is rejecting a start that is too short. The other is ignoring line values near cell edges. The bench drives its enable pulses itself and places every line change at a chosen pulse count. It sends a short low pulse that ends before the half-bit point, and it sends data cells whose edge pulses carry the inverted bit. A correct result then proves both the glitch rejection and the centre sampling. Overrun is reached by holding `out_ready` low across two complete characters.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int CHAR_W = 8;
    localparam int CNT_W  = 6;
    localparam int IDX_W  = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    localparam logic [1:0] MODE_X1 = 2'd0;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       line,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    output logic       done,
    output rx_char_t   char_o
);
    rx_state_e         state, nxt;
    logic [CNT_W-1:0]  tick_cnt;
    logic [CNT_W-1:0]  full_m1, half_m1;
    logic [IDX_W-1:0]  bit_idx, last_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_err_q;
    logic              bit_pt, half_pt;

    always_comb begin
        unique case (cfg_mode)
            2'd0:    begin full_m1 = 6'd0;  half_m1 = 6'd0;  end
            2'd1:    begin full_m1 = 6'd15; half_m1 = 6'd7;  end
            2'd2:    begin full_m1 = 6'd31; half_m1 = 6'd15; end
            default: begin full_m1 = 6'd63; half_m1 = 6'd31; end
        endcase
    end

    assign last_idx = IDX_W'(cfg_len) + IDX_W'(4);
    assign bit_pt   = tick_en && (tick_cnt == full_m1);
    assign half_pt  = tick_en && (tick_cnt == half_m1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick_en && !line)
                           nxt = (cfg_mode == MODE_X1) ? ST_DATA : ST_START;
            ST_START:  if (half_pt)
                           nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_pt && bit_idx == last_idx)
                           nxt = cfg_par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_pt) nxt = ST_STOP;
            ST_STOP:   if (bit_pt) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt  <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_err_q <= 1'b0;
            done      <= 1'b0;
            char_o    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    tick_cnt <= '0;
                    bit_idx  <= '0;
                    if (tick_en && !line) begin
                        shreg     <= '0;
                        par_err_q <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick_en) tick_cnt <= half_pt ? '0 : tick_cnt + 1'b1;
                end
                ST_DATA: begin
                    if (bit_pt) begin
                        tick_cnt       <= '0;
                        shreg[bit_idx] <= line;
                        bit_idx        <= bit_idx + 1'b1;
                    end else if (tick_en) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (bit_pt) begin
                        tick_cnt  <= '0;
                        par_err_q <= (^shreg) ^ line ^ !cfg_par_even;
                    end else if (tick_en) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_pt) begin
                        tick_cnt       <= '0;
                        done           <= 1'b1;
                        char_o.data    <= shreg;
                        char_o.par_err <= par_err_q;
                        char_o.frm_err <= !line;
                    end else if (tick_en) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                default: tick_cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import serial_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_char_t char_i,
    input  logic     ready,
    output logic     valid,
    output rx_char_t char_o,
    output logic     overrun
);
    logic pop;
    assign pop = valid && ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            overrun <= 1'b0;
            char_o  <= '0;
        end else if (push && (!valid || pop)) begin
            valid   <= 1'b1;
            overrun <= 1'b0;
            char_o  <= char_i;
        end else if (push) begin
            overrun <= 1'b1;
        end else if (pop) begin
            valid   <= 1'b0;
            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_line,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_strip_en,
    input  logic [CHAR_W-1:0] cfg_match,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_par_err,
    output logic              out_frm_err,
    output logic              out_overrun
);
    logic     line_s;
    logic     frame_done;
    logic     frame_push;
    rx_char_t frame_char;
    rx_char_t held;

    rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s)
    );

    rx_frame_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .tick_en(sample_en), .line(line_s),
        .cfg_mode(cfg_mode), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .done(frame_done), .char_o(frame_char)
    );

    assign frame_push = frame_done &&
                        !(cfg_strip_en && frame_char.data == cfg_match);

    rx_hold hold_i (
        .clk(clk), .rst_n(rst_n), .push(frame_push), .char_i(frame_char),
        .ready(out_ready), .valid(out_valid), .char_o(held),
        .overrun(out_overrun)
    );

    assign out_data    = held.data;
    assign out_par_err = held.par_err;
    assign out_frm_err = held.frm_err;
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_par_err,
    input logic       out_frm_err,
    input logic       out_overrun,
    input logic [1:0] cfg_len,
    input logic       cfg_strip_en,
    input logic [7:0] cfg_match,
    input logic       frame_push
);
    logic [7:0] keep_mask;
    assign keep_mask = 8'hFF >> (2'd3 - cfg_len);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_par_err) && $stable(out_frm_err));

    a_r9_overrun_with_char: assert property (@(posedge clk) disable iff (!rst_n)
        out_overrun |-> out_valid);

    a_r9_overrun_raised: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && frame_push |=> out_overrun && $stable(out_data));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data & ~keep_mask) == 8'h00);

    a_r7_no_match_out: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && cfg_strip_en |-> out_data != cfg_match);

    a_r1_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_overrun);
endmodule

bind serial_char_rx serial_char_rx_chk chk_i (.*);

// File: tb/serial_char_rx_tb_top.sv
module serial_char_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_strip_en = 1'b0;
    logic [7:0] cfg_match = 8'h00;
    logic       out_ready = 1'b0;
    logic       out_valid, out_par_err, out_frm_err, out_overrun;
    logic [7:0] out_data;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    serial_char_rx dut_i (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 16 : (m == 2'd2) ? 32 : 64;
    endfunction

    function automatic logic [7:0] mask_of(input logic [7:0] d, input logic [1:0] l);
        return d & (8'hFF >> (3 - l));
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic even);
        return even ? ^d : ~^d;
    endfunction

    task automatic one_en();
        repeat (3) @(negedge clk);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bpar, input bit bstop,
                              input int nstop, input bit noise);
        int dv = div_of(cfg_mode);
        logic [7:0] md = mask_of(d, cfg_len);
        rx_line = 1'b0;
        repeat (dv) one_en();
        for (int i = 0; i < int'(cfg_len) + 5; i++) begin
            for (int k = 0; k < dv; k++) begin
                if (noise && dv > 1 && (k < 3 || k >= dv - 3)) rx_line = ~md[i];
                else rx_line = md[i];
                one_en();
            end
        end
        if (cfg_par_en) begin
            rx_line = par_bit(md, cfg_par_even) ^ bpar;
            repeat (dv) one_en();
        end
        rx_line = ~bstop;
        repeat (dv) one_en();
        rx_line = 1'b1;
        if (nstop > 1) repeat (dv) one_en();
        repeat ((dv > 1) ? dv / 2 + 2 : 2) one_en();
    endtask

    task automatic pop();
        @(negedge clk) out_ready = 1'b1;
        @(negedge clk) out_ready = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] d, input bit bpar, input bit bstop,
                             input int nstop, input bit noise, input string req);
        logic [7:0] md = mask_of(d, cfg_len);
        bit dropped = cfg_strip_en && (md == cfg_match);
        send_frame(d, bpar, bstop, nstop, noise);
        @(negedge clk);
        check(req, "valid", out_valid, !dropped);
        if (!dropped) begin
            check(req, "data", out_data, md);
            check(req, "par_err", out_par_err, bpar && cfg_par_en);
            check(req, "frm_err", out_frm_err, bstop);
            check(req, "overrun", out_overrun, 1'b0);
            pop();
            check("R8", "valid after read", out_valid, 1'b0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "valid", out_valid, 1'b0);
        check("R1", "overrun", out_overrun, 1'b0);
        check("R1", "flags", {out_par_err, out_frm_err}, 2'b00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10 x1, R4 eight bits
        cfg_mode = 2'd0; cfg_len = 2'd3;
        run_frame(8'hA5, 0, 0, 1, 0, "R10");
        run_frame(8'h3C, 0, 0, 1, 0, "R10");
        // R4 five bits, upper bits zero
        cfg_mode = 2'd1; cfg_len = 2'd0;
        run_frame(8'hFF, 0, 0, 1, 0, "R4");
        cfg_len = 2'd2;
        run_frame(8'hD2, 0, 0, 1, 0, "R4");
        // R5 parity
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        run_frame(8'h71, 0, 0, 1, 0, "R5");
        run_frame(8'h71, 1, 0, 1, 0, "R5");
        cfg_par_even = 1'b0;
        run_frame(8'h0F, 0, 0, 1, 0, "R5");
        run_frame(8'h0E, 1, 0, 1, 0, "R5");
        cfg_par_en = 1'b0;
        // R6 framing and extra stop time
        cfg_mode = 2'd2;
        run_frame(8'h5A, 0, 1, 1, 0, "R6");
        cfg_mode = 2'd1;
        run_frame(8'h81, 0, 0, 2, 0, "R6");
        run_frame(8'h7E, 0, 0, 2, 0, "R6");
        // R2 centre sampling with noisy cell edges
        run_frame(8'h96, 0, 0, 1, 1, "R2");
        cfg_mode = 2'd3;
        run_frame(8'h4B, 0, 0, 1, 1, "R2");
        // R3 glitch rejection
        cfg_mode = 2'd1;
        rx_line = 1'b0; repeat (5) one_en();
        rx_line = 1'b1; repeat (20) one_en();
        @(negedge clk);
        check("R3", "no char from glitch", out_valid, 1'b0);
        run_frame(8'hC3, 0, 0, 1, 0, "R3");
        // R7 strip
        cfg_strip_en = 1'b1; cfg_match = 8'h55;
        run_frame(8'h55, 0, 0, 1, 0, "R7");
        run_frame(8'h55, 0, 1, 1, 0, "R7");
        run_frame(8'h54, 0, 0, 1, 0, "R7");
        cfg_strip_en = 1'b0;
        run_frame(8'h55, 0, 0, 1, 0, "R7");
        // R9 overrun, R8 holding
        send_frame(8'h11, 0, 0, 1, 0);
        send_frame(8'h22, 0, 0, 1, 0);
        @(negedge clk);
        check("R9", "valid", out_valid, 1'b1);
        check("R9", "old data kept", out_data, 8'h11);
        check("R9", "overrun", out_overrun, 1'b1);
        repeat (10) @(negedge clk);
        check("R8", "held data", out_data, 8'h11);
        pop();
        check("R9", "overrun cleared", out_overrun, 1'b0);
        check("R8", "empty", out_valid, 1'b0);
        run_frame(8'h33, 0, 0, 1, 0, "R9");

        // random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d = 8'($urandom);
            int r = $urandom % 8;
            cfg_mode = (r < 3) ? 2'd0 : (r < 6) ? 2'd1 : (r == 6) ? 2'd2 : 2'd3;
            cfg_len = 2'($urandom);
            cfg_par_en = 1'($urandom);
            cfg_par_even = 1'($urandom);
            cfg_strip_en = ($urandom % 4) == 0;
            cfg_match = ($urandom % 2) ? mask_of(d, cfg_len) : 8'($urandom);
            run_frame(d, ($urandom % 4) == 0, ($urandom % 5) == 0,
                      1 + ($urandom % 2), ($urandom % 2) == 1, "R5");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule